// File: doc/BRIEF.md
# Programmable Processor Watchdog Timer

This block watches for a processor that has stopped servicing it. Software programs one 8-bit configuration register with a multiplier, a resolution code and a steering bit. The block then counts ticks of a 16 Hz timebase until it reaches the programmed timeout. Any processor read or write of that register starts the period again. A processor that keeps touching the register therefore never sees an expiry.

When the count runs out, the steering bit picks the action. With steering cleared, a sticky flag is set and an active-low interrupt line is driven low. The line stays low until software reads the flag through a separate flag address or accesses the configuration register. With steering set, the block emits an active-low reset pulse of a fixed width, counted in system clocks. It also clears its own register and the frequency-test enable. The interrupt line is shared with a frequency-test output. An armed, interrupt-steered watchdog takes that line over from the frequency-test output.

Top module: `wdog_timer`

## Requirements
- R1: The register layout is bit 7 = steering, bits 6..2 = multiplier M, bits 1..0 = resolution code C. Ticks per unit are 1, 4, 16 and 64 for C = 00, 01, 10 and 11. Expiry happens on the clock edge that samples the (M × ticks-per-unit)-th tick after the last restart, and not before.
- R2: After reset the configuration register reads 0x00, `irq_ft_n` and `wdog_rst_n` are high, and no expiry occurs however many ticks arrive.
- R3: A register value with M = 0, including 0x00, never produces an expiry, whatever the values of C and the steering bit.
- R4: A read or write of the configuration register (`sel_wdog` together with `bus_rd` or `bus_wr`) restarts the count from zero. An expiry due in the same cycle is cancelled.
- R5: With steering 0, expiry sets the flag and drives `irq_ft_n` low. The flag stays set across further ticks. It is cleared by a flag read (`sel_flag` with `bus_rd`) or by any access to the configuration register. A flag read returns the flag in bit 0 of `bus_rdata` before it is cleared. The other bits read 0.
- R6: With steering 1, expiry drives `wdog_rst_n` low for exactly CLK_HZ/1000 × RST_PULSE_MS clock cycles. RST_PULSE_MS must lie within 40..200 and defaults to 100. The flag is not set.
- R7: With steering 1, expiry clears the configuration register to 0x00 and clears the frequency-test enable.
- R8: The frequency-test enable is set on a rising edge of `ftest_req` and cleared while `ftest_req` is low. When the flag is set, `irq_ft_n` is 0. Otherwise, if M ≠ 0 and steering is 0, it is 1. Otherwise it follows `ftest_src` while the enable is set, and is 1 when the enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| sel_wdog | input | 1 | Address matches the configuration register |
| sel_flag | input | 1 | Address matches the flag register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: the register, the flag in bit 0, or 0 |
| tick16 | input | 1 | One-clock pulse at 16 Hz |
| ftest_req | input | 1 | Frequency-test request level |
| ftest_src | input | 1 | Frequency-test waveform |
| irq_ft_n | output | 1 | Shared active-low interrupt / frequency-test output |
| wdog_rst_n | output | 1 | Active-low reset pulse |

## Verification
The bench builds the block with CLK_HZ = 1000 and RST_PULSE_MS = 100. That makes the reset pulse exactly 100 clocks long, so the bench can count its whole width. The bench drives a tick on every second clock, which is far faster than a real 16 Hz timebase. This brings the longest timeout of 1984 ticks and every resolution code within a short run. It also lets the bench test the exact edge of expiry for steering values 0 and 1.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int unsigned MULT_W   = 5;
   localparam int unsigned RES_W    = 2;
   localparam int unsigned RES_STEP = 2;
   localparam int unsigned REG_W    = 1 + MULT_W + RES_W;
   localparam int unsigned CNT_W    = MULT_W + RES_STEP * ((1 << RES_W) - 1);

   typedef struct packed {
      logic              steer;
      logic [MULT_W-1:0] mult;
      logic [RES_W-1:0]  res;
   } wd_cfg_t;
endpackage

// File: rtl/wdog_count.sv
module wdog_count
   import wdog_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              tick,
   input  logic [MULT_W-1:0] mult,
   input  logic [RES_W-1:0]  res,
   output logic              expire
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] tpu;
   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] pp [MULT_W];
   logic             enable;
   logic             hit;

   assign tpu = CNT_W'(1) << (RES_STEP * res);

   for (genvar i = 0; i < MULT_W; i++) begin : g_pp
      assign pp[i] = mult[i] ? (tpu << i) : '0;
   end

   always_comb begin
      term = '0;
      for (int i = 0; i < MULT_W; i++) term = term + pp[i];
   end

   assign enable = |mult;
   assign hit    = enable & tick & (cnt_q == term - 1'b1);
   assign expire = hit & ~restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (restart || !enable) cnt_q <= '0;
      else if (tick)              cnt_q <= hit ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
   parameter int unsigned LEN = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse_n
);
   localparam int unsigned PW = $clog2(LEN + 1);

   if (LEN == 0) begin : g_bad_len
      $error("wdog_pulse: LEN must be nonzero");
   end

   logic [PW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (fire)         cnt_q <= PW'(LEN);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign pulse_n = (cnt_q == '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int unsigned CLK_HZ       = 100_000_000,
   parameter int unsigned RST_PULSE_MS = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rd,
   input  logic             bus_wr,
   input  logic             sel_wdog,
   input  logic             sel_flag,
   input  logic [REG_W-1:0] bus_wdata,
   output logic [REG_W-1:0] bus_rdata,
   input  logic             tick16,
   input  logic             ftest_req,
   input  logic             ftest_src,
   output logic             irq_ft_n,
   output logic             wdog_rst_n
);
   localparam int unsigned RST_CYC = (CLK_HZ / 1000) * RST_PULSE_MS;

   if (RST_PULSE_MS < 40 || RST_PULSE_MS > 200) begin : g_bad_ms
      $error("wdog_timer: RST_PULSE_MS outside 40..200");
   end
   if (CLK_HZ < 1000) begin : g_bad_clk
      $error("wdog_timer: CLK_HZ must be at least 1000");
   end

   wd_cfg_t cfg_q;
   logic    wd_flag;
   logic    ftest_en;
   logic    ftest_req_q;
   logic    wd_acc;
   logic    wr_wdog;
   logic    flag_rd;
   logic    expire;
   logic    fire_irq;
   logic    fire_rst;
   logic    armed_irq;

   assign wd_acc   = sel_wdog & (bus_rd | bus_wr);
   assign wr_wdog  = sel_wdog & bus_wr;
   assign flag_rd  = sel_flag & bus_rd;
   assign fire_irq = expire & ~cfg_q.steer;
   assign fire_rst = expire &  cfg_q.steer;

   wdog_count u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wd_acc),
      .tick    (tick16),
      .mult    (cfg_q.mult),
      .res     (cfg_q.res),
      .expire  (expire)
   );

   wdog_pulse #(.LEN(RST_CYC)) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fire_rst),
      .pulse_n (wdog_rst_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q <= '0;
      else if (wr_wdog)  cfg_q <= wd_cfg_t'(bus_wdata);
      else if (fire_rst) cfg_q <= '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 wd_flag <= 1'b0;
      else if (fire_irq)          wd_flag <= 1'b1;
      else if (wd_acc || flag_rd) wd_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ftest_req_q <= 1'b0;
         ftest_en    <= 1'b0;
      end else begin
         ftest_req_q <= ftest_req;
         if (fire_rst || !ftest_req) ftest_en <= 1'b0;
         else if (!ftest_req_q)      ftest_en <= 1'b1;
      end
   end

   assign armed_irq = (|cfg_q.mult) & ~cfg_q.steer;

   always_comb begin
      if (wd_flag)       irq_ft_n = 1'b0;
      else if (armed_irq) irq_ft_n = 1'b1;
      else if (ftest_en) irq_ft_n = ftest_src;
      else               irq_ft_n = 1'b1;
   end

   always_comb begin
      if (sel_wdog)      bus_rdata = cfg_q;
      else if (sel_flag) bus_rdata = {{(REG_W-1){1'b0}}, wd_flag};
      else               bus_rdata = '0;
   end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
   parameter int unsigned CLK_HZ       = 100_000_000,
   parameter int unsigned RST_PULSE_MS = 100
) (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_rd,
   input logic       bus_wr,
   input logic       sel_wdog,
   input logic       sel_flag,
   input logic [7:0] cfg,
   input logic       wd_flag,
   input logic       irq_ft_n,
   input logic       wdog_rst_n
);
   localparam int unsigned RST_CYC = (CLK_HZ / 1000) * RST_PULSE_MS;

   logic        acc;
   logic        frd;
   logic [31:0] low_cnt;

   assign acc = sel_wdog & (bus_rd | bus_wr);
   assign frd = sel_flag & bus_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          low_cnt <= '0;
      else if (wdog_rst_n) low_cnt <= '0;
      else                 low_cnt <= low_cnt + 1;
   end

   assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wd_flag && !acc && !frd |=> wd_flag);

   assert_irq_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wd_flag |-> !irq_ft_n);

   assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !wd_flag);

   assert_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[6:2] == 5'd0) |=> !$rose(wd_flag) && !$fell(wdog_rst_n));

   assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdog_rst_n) |-> low_cnt == RST_CYC);

   assert_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdog_rst_n) |-> cfg == 8'h00);

   assert_ftest_denied_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[6:2] != 5'd0) && !cfg[7] && !wd_flag |-> irq_ft_n);
endmodule

bind wdog_timer wdog_timer_chk #(.CLK_HZ(CLK_HZ), .RST_PULSE_MS(RST_PULSE_MS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_rd     (bus_rd),
   .bus_wr     (bus_wr),
   .sel_wdog   (sel_wdog),
   .sel_flag   (sel_flag),
   .cfg        (cfg_q),
   .wd_flag    (wd_flag),
   .irq_ft_n   (irq_ft_n),
   .wdog_rst_n (wdog_rst_n)
);

// File: tb/wdog_timer_tb_top.sv
module wdog_timer_tb_top;
   localparam int unsigned CLK_HZ  = 1000;
   localparam int unsigned PULSE_MS = 100;
   localparam int EXP_PULSE = 100;
   localparam int NV = 8;
   localparam logic [7:0] V_CFG [NV] = '{8'h0E, 8'h04, 8'h05, 8'h7C, 8'h07, 8'h86, 8'h89, 8'hFF};
   localparam int         V_TCK [NV] = '{48, 1, 4, 31, 64, 16, 8, 1984};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_rd = 1'b0, bus_wr = 1'b0, sel_wdog = 1'b0, sel_flag = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       tick16 = 1'b0, ftest_req = 1'b0, ftest_src = 1'b0;
   logic       irq_ft_n, wdog_rst_n;
   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   wdog_timer #(.CLK_HZ(CLK_HZ), .RST_PULSE_MS(PULSE_MS)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .sel_wdog(sel_wdog), .sel_flag(sel_flag), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .tick16(tick16), .ftest_req(ftest_req),
      .ftest_src(ftest_src), .irq_ft_n(irq_ft_n), .wdog_rst_n(wdog_rst_n));

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick16 = 1'b1;
         @(negedge clk) tick16 = 1'b0;
      end
   endtask

   task automatic wr_cfg(input logic [7:0] v);
      @(negedge clk);
      sel_wdog = 1'b1; bus_wr = 1'b1; bus_wdata = v;
      @(negedge clk);
      sel_wdog = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_cfg(output logic [7:0] v);
      @(negedge clk);
      sel_wdog = 1'b1; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      sel_wdog = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic rd_flag(output logic [7:0] v);
      @(negedge clk);
      sel_flag = 1'b1; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      sel_flag = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic pulse_width(output int w);
      w = 0;
      while (!wdog_rst_n && w < 1000) begin
         w++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] rv;
      int w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset state
      rd_cfg(rv);
      check("R2 cfg", rv, 8'h00);
      check("R2 irq", irq_ft_n, 1'b1);
      check("R2 rst", wdog_rst_n, 1'b1);
      ticks(80);
      check("R2 no expiry irq", irq_ft_n, 1'b1);
      check("R2 no expiry rst", wdog_rst_n, 1'b1);

      // R1 R5 R6 R7 vector walk
      for (int v = 0; v < NV; v++) begin
         wr_cfg(V_CFG[v]);
         ticks(V_TCK[v] - 1);
         check("R1 early irq", irq_ft_n, 1'b1);
         check("R1 early rst", wdog_rst_n, 1'b1);
         ticks(1);
         if (!V_CFG[v][7]) begin
            check("R1 R5 expiry irq", irq_ft_n, 1'b0);
            rd_flag(rv);
            check("R5 flag read", rv, 8'h01);
            check("R5 irq cleared", irq_ft_n, 1'b1);
            rd_flag(rv);
            check("R5 flag after read", rv, 8'h00);
         end else begin
            check("R1 R6 expiry rst", wdog_rst_n, 1'b0);
            check("R6 no irq", irq_ft_n, 1'b1);
            pulse_width(w);
            check("R6 width", w, EXP_PULSE);
            rd_cfg(rv);
            check("R7 cfg cleared", rv, 8'h00);
         end
      end

      // R3 zero multiplier
      wr_cfg(8'h00);
      ticks(100);
      check("R3 zero irq", irq_ft_n, 1'b1);
      wr_cfg(8'h03);
      ticks(100);
      check("R3 mult0 irq", irq_ft_n, 1'b1);
      wr_cfg(8'h83);
      ticks(100);
      check("R3 mult0 steer rst", wdog_rst_n, 1'b1);

      // R4 restart by read
      wr_cfg(8'h05);
      ticks(3);
      rd_cfg(rv);
      check("R4 readback", rv, 8'h05);
      ticks(3);
      check("R4 restarted", irq_ft_n, 1'b1);
      ticks(1);
      check("R4 expiry after restart", irq_ft_n, 1'b0);
      // R5 sticky, then cleared by register read and by write
      ticks(10);
      check("R5 sticky", irq_ft_n, 1'b0);
      rd_cfg(rv);
      check("R5 clear by cfg read", irq_ft_n, 1'b1);
      ticks(4);
      check("R5 re-expiry", irq_ft_n, 1'b0);
      wr_cfg(8'h05);
      check("R5 clear by cfg write", irq_ft_n, 1'b1);

      // R8 pin sharing
      wr_cfg(8'h00);
      @(negedge clk) ftest_req = 1'b1; ftest_src = 1'b0;
      @(negedge clk);
      check("R8 ftest low", irq_ft_n, 1'b0);
      ftest_src = 1'b1;
      #1 check("R8 ftest high", irq_ft_n, 1'b1);
      ftest_src = 1'b0;
      wr_cfg(8'h05);
      check("R8 denied", irq_ft_n, 1'b1);
      wr_cfg(8'h85);
      check("R8 steer1 passes ftest", irq_ft_n, 1'b0);
      ticks(4);
      check("R6 steer1 fired", wdog_rst_n, 1'b0);
      check("R7 ftest cleared", irq_ft_n, 1'b1);
      rd_cfg(rv);
      check("R7 cfg zero", rv, 8'h00);
      @(negedge clk) ftest_req = 1'b0;
      @(negedge clk) ftest_req = 1'b1;
      @(negedge clk);
      check("R8 re-request", irq_ft_n, 1'b0);
      @(negedge clk) ftest_req = 1'b0;
      @(negedge clk);
      check("R8 request dropped", irq_ft_n, 1'b1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule